// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management transactions to an external PHY. Software builds the complete 32-bit management frame itself (start pattern, opcode, PHY address, register address, turnaround and data) and writes it into the data register. Writing that register starts a transaction. The block then drives 32 preamble bits at logic one, followed by the 32 frame bits, most significant first, on the MDC/MDIO pair.

On a read frame the block stops driving MDIO from the turnaround onward. It samples the 16 data bits returned by the PHY on rising MDC edges and places them in the low half of the data register. Completion sets an event bit that software clears by writing one to it. An interrupt output follows that event bit when the matching mask bit is set. A speed register sets the MDC half-period in system clocks; a value of zero keeps MDC still and blocks new transactions.

The bus side is a simple word-addressed register port with a registered read path. MDIO is presented as separate output, output-enable and input signals, so that the pad is built outside the block.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Four word registers are selected by `bus_addr`: 0 = data (32 bits), 1 = speed (field in bits 6:1, other bits read 0), 2 = event (bit 23), 3 = mask (bit 23). A read strobe returns the selected value on `bus_rdata` one clock later.
- R2: While the speed field is zero, a data write is discarded: the data register keeps its value, no transaction starts, and MDC stays low.
- R3: During a transaction MDC starts low on the clock that accepts the data write. It toggles every `speed` system clocks, so its period is 2 x speed clocks. MDC is low whenever the block is idle.
- R4: A transaction drives 64 bit periods, each one MDC period long and changing together with the falling edge of MDC. The first 32 periods are all ones; the next 32 carry the written word from bit 31 down to bit 0.
- R5: For a read frame (bits 29:28 = 10), `mdio_oe` drops at the first turnaround bit (word bit 17) and stays low to the end. Any other frame drives the whole time. When idle, `mdio_oe` is low and `mdio_o` is high.
- R6: A read samples `mdio_i` on the rising MDC edges of the 16 data bits, most significant first. At completion it writes them to data register bits 15:0, and bits 31:16 keep the command. A non-read frame leaves the data register unchanged.
- R7: A data register write during a transaction is ignored: it neither changes the register nor disturbs the transaction in progress.
- R8: The event bit (bit 23) is set on the clock edge 128 x speed clocks after the accepting edge. Writing 1 to bit 23 of the event register clears it, and writing 0 has no effect. If set and clear fall on the same edge, set wins.
- R9: `irq` is high exactly when both the event bit and the mask bit are set, and it changes on the same clock as they do.
- R10: After a synchronous reset, all registers read 0, MDC is low, `mdio_o` is high, `mdio_oe` is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO value seen at the pad |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench builds the block with its default 6-bit speed field. It programs half-periods of 2 and 3 clocks, which keeps a full 64-bit transaction within a few hundred cycles. That makes it cheap to follow every bit period, the turnaround release and the rising-edge sampling cycle by cycle against a behavioural model. The short transactions also let the bench line up a one-to-clear write on exactly the completion edge, and exercise writes made while busy and while the speed field is zero.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_SPEED = 2'd1,
    SEL_EVENT = 2'd2,
    SEL_MASK  = 2'd3
  } reg_sel_e;

  localparam int        EV_BIT    = 23;     // completion bit in event/mask
  localparam int        PRE_BITS  = 32;     // preamble length in MDC periods
  localparam int        WORD_BITS = 32;     // frame word width
  localparam int        RDAT_BITS = 16;     // read data width
  localparam int        TA_HI     = 17;     // first turnaround bit in the word
  localparam logic [1:0] OP_READ  = 2'b10;  // opcode bits 29:28 for a read
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SPD_W-1:0] half,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [SPD_W-1:0] div_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap     = run && (div_q == half - 1'b1);
  assign rise_stb = wrap && !mdc_q;
  assign fall_stb = wrap && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mdc_q);
  // R3
  mdc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE  = PRE_BITS,
  parameter int WORD = WORD_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WORD-1:0] cmd_in,
  input  logic            rise_stb,
  input  logic            fall_stb,
  input  logic            mdio_i,
  output logic            busy,
  output logic            done,
  output logic            is_read,
  output logic [RDAT_BITS-1:0] rx_data,
  output logic            mdio_o,
  output logic            mdio_oe
);
  localparam int TOTAL = PRE + WORD;
  localparam int CNT_W = $clog2(TOTAL);
  localparam int IW    = $clog2(WORD);
  localparam logic [CNT_W-1:0] LAST_K = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] PRE_K  = CNT_W'(PRE);
  localparam logic [CNT_W-1:0] REL_K  = CNT_W'(PRE + WORD - 1 - TA_HI);
  localparam logic [CNT_W-1:0] DAT_K  = CNT_W'(TOTAL - RDAT_BITS);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] k_q, k_n;
  logic [WORD-1:0]  cmd_q, cmd_n;
  logic             rd_q, rd_n;
  logic [RDAT_BITS-1:0] rx_q;
  logic             o_q, oe_q, o_n, oe_n;
  logic [IW-1:0]    pos;
  logic             last;

  assign last = (k_q == LAST_K);
  assign done = busy_q && fall_stb && last;

  always_comb begin
    busy_n = busy_q;
    k_n    = k_q;
    cmd_n  = cmd_q;
    rd_n   = rd_q;
    if (start) begin
      busy_n = 1'b1;
      k_n    = '0;
      cmd_n  = cmd_in;
      rd_n   = (cmd_in[29:28] == OP_READ);
    end else if (busy_q && fall_stb) begin
      if (last) busy_n = 1'b0;
      else      k_n    = k_q + 1'b1;
    end
  end

  assign pos  = IW'(LAST_K - k_n);
  assign o_n  = !busy_n || (k_n < PRE_K) || cmd_n[pos];
  assign oe_n = busy_n && !(rd_n && (k_n >= REL_K));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      cmd_q  <= '0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_n;
      k_q    <= k_n;
      cmd_q  <= cmd_n;
      rd_q   <= rd_n;
      o_q    <= o_n;
      oe_q   <= oe_n;
      if (busy_q && rd_q && rise_stb && (k_q >= DAT_K))
        rx_q <= {rx_q[RDAT_BITS-2:0], mdio_i};
    end
  end

  assign busy    = busy_q;
  assign is_read = rd_q;
  assign rx_data = rx_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  // R4
  preamble_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (k_q < PRE_K)) |-> o_q);
  // R5
  write_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !rd_q) |-> oe_q);
  // R5
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!oe_q && o_q));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6,
  parameter int DW    = WORD_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             busy,
  input  logic             done,
  input  logic             is_read,
  input  logic [RDAT_BITS-1:0] rx_data,
  output logic             start,
  output logic [SPD_W-1:0] speed,
  output logic             irq
);
  logic [DW-1:0]    data_q, rdata_q;
  logic [SPD_W-1:0] speed_q;
  logic             ev_q, ev_n, mask_q, mask_n, irq_q;
  logic             wr_data, wr_ev, wr_mask, wr_speed;

  assign wr_data  = we && (addr == SEL_DATA);
  assign wr_speed = we && (addr == SEL_SPEED);
  assign wr_ev    = we && (addr == SEL_EVENT);
  assign wr_mask  = we && (addr == SEL_MASK);
  assign start    = wr_data && !busy && (speed_q != '0);

  always_comb begin
    ev_n = ev_q;
    if (done)                       ev_n = 1'b1;
    else if (wr_ev && wdata[EV_BIT]) ev_n = 1'b0;
    mask_n = wr_mask ? wdata[EV_BIT] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      speed_q <= '0;
      ev_q    <= 1'b0;
      mask_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (start)
        data_q <= wdata;
      else if (done && is_read)
        data_q[RDAT_BITS-1:0] <= rx_data;
      if (wr_speed) speed_q <= wdata[SPD_W:1];
      ev_q   <= ev_n;
      mask_q <= mask_n;
      irq_q  <= ev_n && mask_n;
      if (re) begin
        case (addr)
          SEL_DATA:  rdata_q <= data_q;
          SEL_SPEED: rdata_q <= {{(DW-SPD_W-1){1'b0}}, speed_q, 1'b0};
          SEL_EVENT: rdata_q <= DW'(ev_q) << EV_BIT;
          default:   rdata_q <= DW'(mask_q) << EV_BIT;
        endcase
      end
    end
  end

  assign rdata = rdata_q;
  assign speed = speed_q;
  assign irq   = irq_q;

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && wr_data) |=> $stable(data_q));
  // R2
  zero_speed_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !busy && (speed_q == '0)) |=> ($stable(data_q) && !busy));
  // R8
  event_set_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> ev_q);
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (ev_q && mask_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);
  logic             start, busy, done, is_read, rise_stb, fall_stb;
  logic [SPD_W-1:0] speed;
  logic [RDAT_BITS-1:0] rx_data;

  mdio_regs #(.SPD_W(SPD_W), .DW(WORD_BITS)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
    .is_read(is_read), .rx_data(rx_data), .start(start), .speed(speed),
    .irq(irq)
  );

  mdio_clkgen #(.SPD_W(SPD_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(busy), .half(speed), .mdc(mdc),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_shifter #(.PRE(PRE_BITS), .WORD(WORD_BITS)) u_shift (
    .clk(clk), .rst(rst), .start(start), .cmd_in(bus_wdata),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .done(done), .is_read(is_read), .rx_data(rx_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .irq(irq)
  );

  // behavioural reference state
  bit          m_busy, m_ev, m_mask;
  int          m_t, m_spd;
  logic [31:0] m_cmd, m_data, m_rdata;
  logic [15:0] phy_val = 16'h0000;
  int          errors = 0, checks = 0;
  bit          finished = 0;

  localparam logic [31:0] EVB = 32'h0080_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_is_read();
    return m_cmd[29:28] == 2'b10;
  endfunction

  function automatic int m_bit();
    return m_busy ? m_t / (2 * m_spd) : 0;
  endfunction

  always @(posedge clk) begin
    bit acc, fin;
    if (rst) begin
      m_busy = 0; m_ev = 0; m_mask = 0; m_t = 0; m_spd = 0;
      m_cmd = 0; m_data = 0; m_rdata = 0;
    end else begin
      if (bus_re) begin
        case (bus_addr)
          2'd0: m_rdata = m_data;
          2'd1: m_rdata = 32'(m_spd) << 1;
          2'd2: m_rdata = m_ev ? EVB : 32'd0;
          default: m_rdata = m_mask ? EVB : 32'd0;
        endcase
      end
      acc = bus_we && bus_addr == 2'd0 && !m_busy && m_spd != 0;
      fin = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == 128 * m_spd) begin
          m_busy = 0; m_ev = 1; fin = 1;
          if (m_is_read()) m_data[15:0] = phy_val;
        end
      end
      if (acc) begin
        m_busy = 1; m_t = 0; m_cmd = bus_wdata; m_data = bus_wdata;
      end
      if (bus_we && bus_addr == 2'd1) m_spd = int'(bus_wdata[6:1]);
      if (bus_we && bus_addr == 2'd2 && bus_wdata[23] && !fin) m_ev = 0;
      if (bus_we && bus_addr == 2'd3) m_mask = bus_wdata[23];
    end
  end

  // PHY model: drives returned data during the data bits of a read
  always @(negedge clk) begin
    int k;
    k = m_bit();
    if (m_busy && m_is_read() && k >= 48) mdio_i = phy_val[63 - k];
    else mdio_i = 1'b1;
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    int k;
    logic e_mdc, e_o, e_oe;
    if (!rst) begin
      k     = m_bit();
      e_mdc = m_busy ? 1'((m_t / m_spd) % 2) : 1'b0;
      e_o   = !m_busy || k < 32 || m_cmd[63 - k];
      e_oe  = m_busy && !(m_is_read() && k >= 46);
      chk("R3 mdc", {31'd0, mdc}, {31'd0, e_mdc});
      chk("R4 mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
      chk("R5 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
      chk("R9 irq", {31'd0, irq}, {31'd0, m_ev && m_mask});
      chk("R1 rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] cmd_rd, cmd_wr;
    cmd_rd = 32'h6002_0000 | (32'd5 << 23) | (32'd2 << 18);
    cmd_wr = 32'h5002_0000 | (32'd1 << 23) | (32'd4 << 18) | 32'h1234;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 mdc", {31'd0, mdc}, 32'd0);
    chk("R10 mdio_o", {31'd0, mdio_o}, 32'd1);
    chk("R10 mdio_oe", {31'd0, mdio_oe}, 32'd0);
    chk("R10 irq", {31'd0, irq}, 32'd0);
    rd_chk(2'd1, 32'd0, "R10 speed reset");
    rd_chk(2'd0, 32'd0, "R10 data reset");

    // R2: speed zero blocks transactions
    wr(2'd0, cmd_rd);
    repeat (20) begin
      @(negedge clk);
      chk("R2 mdc still", {31'd0, mdc}, 32'd0);
    end
    rd_chk(2'd0, 32'd0, "R2 data unchanged");

    // R1 register readback
    wr(2'd1, 32'd4);
    rd_chk(2'd1, 32'd4, "R1 speed readback");
    wr(2'd3, EVB);
    rd_chk(2'd3, EVB, "R1 mask readback");

    // R6 read transaction, R7 write while busy
    phy_val = 16'hA5C3;
    wr(2'd0, cmd_rd);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h5002_FFFF);
    wait_idle();
    rd_chk(2'd0, {cmd_rd[31:16], 16'hA5C3}, "R6 R7 read data");
    rd_chk(2'd2, EVB, "R8 event set");
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'd0);
    rd_chk(2'd2, EVB, "R8 zero write keeps");
    wr(2'd2, EVB);
    rd_chk(2'd2, 32'd0, "R8 cleared");
    chk("R9 irq low", {31'd0, irq}, 32'd0);

    // write frame at another speed
    wr(2'd1, 32'd6);
    wr(2'd0, cmd_wr);
    wait_idle();
    rd_chk(2'd0, cmd_wr, "R6 write frame leaves data");
    rd_chk(2'd2, EVB, "R8 event after write");
    wr(2'd2, EVB);

    // R8 set wins over clear on the same edge
    phy_val = 16'h3C96;
    wr(2'd0, cmd_rd);
    do @(negedge clk); while (!(m_busy && m_t == 128 * m_spd - 1));
    bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = EVB;
    @(negedge clk);
    bus_we = 1'b0;
    rd_chk(2'd2, EVB, "R8 set wins");
    rd_chk(2'd0, {cmd_rd[31:16], 16'h3C96}, "R6 second read");
    wr(2'd3, 32'd0);
    @(negedge clk);
    chk("R9 masked", {31'd0, irq}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule